// File: doc/BRIEF.md
# Streaming Offset Stage

This block is one stage of a sample-stream pipeline. Each sample that enters on the input stream leaves on the output stream with a programmable offset added to it. The offset is a register that is written and read through a small register port of address, write data, write strobe and read data. A stage can stand alone, or many stages can be wired output to input in a row. Stalls from the far end travel back through every stage, and no sample is lost or repeated on the way.

Each side of the stage has a small FIFO of `DEPTH` entries. The input FIFO drives `in_ready` from a flop. The output FIFO drives `out_valid` and `out_data` from flops. Between the two FIFOs, a one-entry slot is controlled by a three-state machine and computes the sum. Its states are `SLOT_EMPTY`, `SLOT_FULL` and `SLOT_STALLED`. Its transitions are:

- take: `SLOT_EMPTY` to `SLOT_FULL` when the input FIFO offers a sample.
- refill: `SLOT_FULL` or `SLOT_STALLED` to `SLOT_FULL` when the slot empties and reloads in the same cycle.
- drain: `SLOT_FULL` or `SLOT_STALLED` to `SLOT_EMPTY` when the slot empties and nothing is waiting.
- block: `SLOT_FULL` or `SLOT_STALLED` to `SLOT_STALLED` when the output FIFO has no room.

Because every output is a flop, a chain of stages has no combinational path from one stage to the next. Timing along the chain is therefore set by the handshakes alone, and no delay balancing is needed.

Top module: `stream_offset_stage`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and a read of the offset register returns 0.
- R2: Each output sample equals the input sample plus the offset, taken modulo 2^WIDTH. A sum that overflows wraps around.
- R3: Each input handshake (`in_valid` and `in_ready` both high at a clock edge) carries exactly one sample. Samples leave in the order they arrived, with none lost and none duplicated.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged at the next edge.
- R5: `in_ready` is 0 whenever the input FIFO holds DEPTH-1 or more entries. If the output is blocked from reset, exactly 2*(DEPTH-1)+1 samples are accepted before `in_ready` stays low: DEPTH-1 in each FIFO plus one in the slot.
- R6: A write with `attr_we`=1 and `attr_addr`=AMOUNT_ADDR (default 0) loads `attr_wdata` into the offset register. `attr_rdata` shows the register addressed one clock edge earlier.
- R7: A write to any other address leaves the offset unchanged. A read from any other address returns 0.
- R8: An offset change applies only to samples that move from the input FIFO into the slot after the write edge. Samples already in the slot or in the output FIFO keep the offset that was in force when they were summed.
- R9: On an idle, unblocked stage, a sample accepted at clock edge e0 first shows `out_valid`=1 after edge e0+2 and not earlier. The stage then passes one sample per cycle.
- R10: In a chain of stages with random stalls at both ends, the output stream is the input stream plus the sum of all the stage offsets (mod 2^WIDTH), in order, with no loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | WIDTH | Input sample |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage can accept a sample (from a flop) |
| out_data | output | WIDTH | Output sample (from a flop) |
| out_valid | output | 1 | Output sample present (from a flop) |
| out_ready | input | 1 | Downstream accepts the output sample |
| attr_addr | input | ADDR_W | Register port address |
| attr_wdata | input | WIDTH | Register write data |
| attr_we | input | 1 | Register write strobe |
| attr_rdata | output | WIDTH | Register read data, one cycle after the address |

## Verification
Assertions check the following on every cycle:

- the output holds steady while it is stalled;
- the slot keeps its contents while it is blocked;
- neither FIFO is written when full or read when empty;
- writes to unmapped addresses leave the offset alone.

Some behaviours only the bench's scenarios can show:

- wraparound of the sum;
- exact ordering over a long chain with random stalls;
- the accepted count of 2*(DEPTH-1)+1 under a full block;
- the three-edge latency;
- the rule that a new offset applies only to samples summed after it is written.

// File: rtl/soff_pkg.sv
package soff_pkg;

    // Occupancy of the single adder slot between the two FIFOs
    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_FULL    = 2'd1,
        SLOT_STALLED = 2'd2
    } slot_state_e;

endpackage

// File: rtl/soff_fifo.sv
module soff_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic             space_o,
    input  logic             pop_i,
    output logic             head_valid_o,
    output logic [WIDTH-1:0] head_data_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] LIMIT    = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CAPACITY = CW'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q, wr_ptr_n, rd_ptr_n;
    logic [CW-1:0]    count_q, count_n;
    logic [WIDTH-1:0] head_q, head_n;
    logic             valid_q, space_q;

    always_comb begin
        wr_ptr_n = wr_ptr_q;
        rd_ptr_n = rd_ptr_q;
        if (push_i) wr_ptr_n = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
        if (pop_i)  rd_ptr_n = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
        count_n = count_q + CW'(push_i) - CW'(pop_i);
        // the next head is either already stored or is being written now
        if (push_i && (wr_ptr_q == rd_ptr_n)) head_n = push_data_i;
        else                                  head_n = mem_q[rd_ptr_n];
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[wr_ptr_q] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            head_q   <= '0;
            valid_q  <= 1'b0;
            space_q  <= 1'b1;
        end else begin
            wr_ptr_q <= wr_ptr_n;
            rd_ptr_q <= rd_ptr_n;
            count_q  <= count_n;
            head_q   <= head_n;
            valid_q  <= (count_n != '0);
            space_q  <= (count_n < LIMIT);
        end
    end

    assign space_o      = space_q;
    assign head_valid_o = valid_q;
    assign head_data_o  = head_q;

    // R5: a write never lands on a full FIFO
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_q < CAPACITY));

    // R3: a read never takes from an empty FIFO
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (count_q != '0));

endmodule

// File: rtl/soff_attr_regs.sv
module soff_attr_regs #(
    parameter int WIDTH       = 16,
    parameter int ADDR_W      = 4,
    parameter int AMOUNT_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic              we_i,
    output logic [WIDTH-1:0]  rdata_o,
    output logic [WIDTH-1:0]  amount_o
);
    localparam logic [ADDR_W-1:0] AMT_SEL = ADDR_W'(AMOUNT_ADDR);

    logic [WIDTH-1:0] amount_q, rdata_q;
    logic             hit;

    assign hit = (addr_i == AMT_SEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amount_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (we_i && hit) amount_q <= wdata_i;
            rdata_q <= hit ? amount_q : '0;
        end
    end

    assign amount_o = amount_q;
    assign rdata_o  = rdata_q;

    // R7: writes elsewhere in the address space do not touch the offset
    assert_foreign_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !hit) |=> $stable(amount_q));

endmodule

// File: rtl/soff_core.sv
module soff_core
    import soff_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_valid_i,
    input  logic [WIDTH-1:0] src_data_i,
    output logic             src_pop_o,
    input  logic [WIDTH-1:0] amount_i,
    input  logic             dst_space_i,
    output logic             dst_push_o,
    output logic [WIDTH-1:0] dst_data_o
);
    slot_state_e      state_q, state_n;
    logic [WIDTH-1:0] slot_q;
    logic             slot_free;

    // outputs and next state
    always_comb begin
        dst_push_o = (state_q != SLOT_EMPTY) && dst_space_i;
        slot_free  = (state_q == SLOT_EMPTY) || dst_push_o;
        src_pop_o  = src_valid_i && slot_free;
        state_n    = state_q;
        unique case (state_q)
            SLOT_EMPTY:   state_n = src_pop_o ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL,
            SLOT_STALLED: begin
                if (!dst_push_o)    state_n = SLOT_STALLED;
                else if (src_pop_o) state_n = SLOT_FULL;
                else                state_n = SLOT_EMPTY;
            end
            default:      state_n = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            slot_q  <= '0;
        end else begin
            state_q <= state_n;
            if (src_pop_o) slot_q <= src_data_i + amount_i;
        end
    end

    assign dst_data_o = slot_q;

    // R4: a blocked slot keeps its sample and records the stall
    assert_slot_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != SLOT_EMPTY) && !dst_push_o) |=> ((state_q == SLOT_STALLED) && $stable(slot_q)));

endmodule

// File: rtl/stream_offset_stage.sv
module stream_offset_stage #(
    parameter int WIDTH       = 16,
    parameter int DEPTH       = 16,
    parameter int ADDR_W      = 4,
    parameter int AMOUNT_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [WIDTH-1:0]  out_data,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic [WIDTH-1:0]  attr_wdata,
    input  logic              attr_we,
    output logic [WIDTH-1:0]  attr_rdata
);
    logic             ib_push, ib_valid, ib_pop;
    logic [WIDTH-1:0] ib_data;
    logic             ob_push, ob_space, ob_pop;
    logic [WIDTH-1:0] ob_wdata;
    logic [WIDTH-1:0] amount;

    assign ib_push = in_valid && in_ready;
    assign ob_pop  = out_valid && out_ready;

    soff_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_in_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (ib_push),
        .push_data_i  (in_data),
        .space_o      (in_ready),
        .pop_i        (ib_pop),
        .head_valid_o (ib_valid),
        .head_data_o  (ib_data)
    );

    soff_attr_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .AMOUNT_ADDR(AMOUNT_ADDR)) u_attr (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (attr_addr),
        .wdata_i  (attr_wdata),
        .we_i     (attr_we),
        .rdata_o  (attr_rdata),
        .amount_o (amount)
    );

    soff_core #(.WIDTH(WIDTH)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_valid_i (ib_valid),
        .src_data_i  (ib_data),
        .src_pop_o   (ib_pop),
        .amount_i    (amount),
        .dst_space_i (ob_space),
        .dst_push_o  (ob_push),
        .dst_data_o  (ob_wdata)
    );

    soff_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_out_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (ob_push),
        .push_data_i  (ob_wdata),
        .space_o      (ob_space),
        .pop_i        (ob_pop),
        .head_valid_o (out_valid),
        .head_data_o  (out_data)
    );

    // R4: a stalled output keeps its sample in place
    assert_hold_under_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/stream_offset_stage_test.sv
module stream_offset_stage_test;
    localparam int W     = 16;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int NCH   = 3;
    localparam int NSMP  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // single stage under directed test
    logic [W-1:0]  in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  out_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] attr_addr = '0;
    logic [W-1:0]  attr_wdata = '0;
    logic          attr_we = 1'b0;
    logic [W-1:0]  attr_rdata;

    stream_offset_stage #(.WIDTH(W), .DEPTH(DEPTH), .ADDR_W(AW), .AMOUNT_ADDR(0)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .attr_addr(attr_addr), .attr_wdata(attr_wdata), .attr_we(attr_we),
        .attr_rdata(attr_rdata)
    );

    // chain of stages
    logic [W-1:0]   ch_data  [NCH+1];
    logic           ch_valid [NCH+1];
    logic           ch_ready [NCH+1];
    logic [W-1:0]   ch_rdata [NCH];
    logic [W-1:0]   src_data = '0;
    logic           src_valid = 1'b0;
    logic           snk_ready = 1'b0;
    logic [NCH-1:0] ch_we = '0;
    logic [AW-1:0]  ch_addr = '0;
    logic [W-1:0]   ch_wdata = '0;

    assign ch_data[0]    = src_data;
    assign ch_valid[0]   = src_valid;
    assign ch_ready[NCH] = snk_ready;

    for (genvar g = 0; g < NCH; g++) begin : g_chain
        stream_offset_stage #(.WIDTH(W), .DEPTH(DEPTH), .ADDR_W(AW), .AMOUNT_ADDR(0)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .in_data(ch_data[g]), .in_valid(ch_valid[g]), .in_ready(ch_ready[g]),
            .out_data(ch_data[g+1]), .out_valid(ch_valid[g+1]), .out_ready(ch_ready[g+1]),
            .attr_addr(ch_addr), .attr_wdata(ch_wdata), .attr_we(ch_we[g]),
            .attr_rdata(ch_rdata[g])
        );
    end

    // {offset, sample, expected}
    localparam logic [47:0] VEC [8] = '{
        {16'h0000, 16'h1234, 16'h1234},
        {16'h0001, 16'hFFFF, 16'h0000},
        {16'h0100, 16'h00FF, 16'h01FF},
        {16'hFFFF, 16'h0001, 16'h0000},
        {16'h8000, 16'h8000, 16'h0000},
        {16'h0005, 16'h7FFA, 16'h7FFF},
        {16'hABCD, 16'h1111, 16'hBCDE},
        {16'h0003, 16'hFFFE, 16'h0001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic attr_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        attr_addr = a; attr_wdata = d; attr_we = 1'b1;
        @(negedge clk);
        attr_we = 1'b0;
    endtask

    task automatic attr_read(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        attr_addr = a;
        @(negedge clk);
        d = attr_rdata;
    endtask

    task automatic push1(input logic [W-1:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop1(output logic [W-1:0] d, output bit ok);
        ok = 1'b0;
        d = '0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_valid) begin
                d = out_data; ok = 1'b1; out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] d;
        bit ok;
        int accepted, rcv, sent;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
        attr_read(0, d);
        chk("R1 offset", d, 0);

        // R2: vector table, one sample per offset
        for (int i = 0; i < 8; i++) begin
            attr_write(0, VEC[i][47:32]);
            push1(VEC[i][31:16]);
            pop1(d, ok);
            chk("R2 arrived", ok, 1);
            chk("R2 sum", d, VEC[i][15:0]);
        end

        // R6 and R7: register port
        attr_write(0, 16'h0055);
        attr_write(3, 16'h0099);
        attr_read(0, d);
        chk("R6 readback", d, 16'h0055);
        attr_read(3, d);
        chk("R7 unmapped read", d, 0);
        push1(16'h0100);
        pop1(d, ok);
        chk("R7 offset untouched", d, 16'h0155);

        // R9: latency from an accepted sample to the output
        @(negedge clk);
        in_data = 16'h0001; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 after e0", out_valid, 0);
        @(negedge clk);
        chk("R9 after e1", out_valid, 0);
        @(negedge clk);
        chk("R9 after e2", out_valid, 1);
        chk("R9 data", out_data, 16'h0056);
        pop1(d, ok);

        // R4 and R3: stall holds the head, order preserved
        push1(16'h0010); push1(16'h0020); push1(16'h0030);
        repeat (6) @(negedge clk);
        chk("R4 valid held", out_valid, 1);
        chk("R4 head", out_data, 16'h0065);
        repeat (4) @(negedge clk);
        chk("R4 head stable", out_data, 16'h0065);
        pop1(d, ok); chk("R3 order 0", d, 16'h0065);
        pop1(d, ok); chk("R3 order 1", d, 16'h0075);
        pop1(d, ok); chk("R3 order 2", d, 16'h0085);

        // R8: offset change does not touch samples already summed
        attr_write(0, 16'h0010);
        push1(16'h1000); push1(16'h2000);
        repeat (6) @(negedge clk);
        attr_write(0, 16'h0020);
        push1(16'h3000);
        repeat (6) @(negedge clk);
        pop1(d, ok); chk("R8 old offset a", d, 16'h1010);
        pop1(d, ok); chk("R8 old offset b", d, 16'h2010);
        pop1(d, ok); chk("R8 new offset", d, 16'h3020);

        // R5: capacity under a fully blocked output
        accepted = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = 16'(16'h4000 + accepted);
            if (in_ready) accepted++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 accepted", accepted, 2 * (DEPTH - 1) + 1);
        chk("R5 ready low", in_ready, 0);
        for (int k = 0; k < accepted; k++) begin
            pop1(d, ok);
            chk("R3 drain order", d, 16'(16'h4020 + k));
        end

        // R10: chain with random stalls
        for (int g = 0; g < NCH; g++) begin
            @(negedge clk);
            ch_addr = '0; ch_wdata = 16'(3 + 2 * g); ch_we = NCH'(1 << g);
            @(negedge clk);
            ch_we = '0;
        end
        rcv = 0; sent = 0;
        for (int cyc = 0; cyc < 8000 && rcv < NSMP; cyc++) begin
            @(negedge clk);
            snk_ready = ($urandom % 10) < 6;
            if (ch_valid[NCH] && snk_ready) begin
                chk("R10 chain sample", ch_data[NCH], 16'(rcv * 7 + 3 + 15));
                rcv++;
            end
            src_valid = (sent < NSMP) && (($urandom % 10) < 7);
            src_data = 16'(sent * 7 + 3);
            if (src_valid && ch_ready[0]) sent++;
        end
        @(negedge clk);
        src_valid = 1'b0;
        chk("R10 chain count", rcv, NSMP);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule